// File: doc/BRIEF.md
# Floating-Point Register Producer Table

This block is the register-side half of a dynamically scheduled floating-point unit. Each architectural register has a producer tag and a value. The tag names the station that will next write the register, and zero means no write is pending. The architectural registers are the even-numbered registers 0, 2, up to 30. Index i (0 to 15) selects register 2i.

In each cycle the two source lookups return one of two things for each operand. If no producer is pending, they return the register value. If a producer is pending, they return that producer's tag. An issue records the issuing station as the new producer of its destination, even when an older producer is still outstanding.

The block watches the result broadcast bus. A broadcast lands in a register only when its tag equals the producer currently recorded for that register. So when several writers of one register overlap, only the youngest can update it, and stale results fall away.

Top module: `fp_rename_table`

## Requirements
- R1: After reset, or an asynchronous reset in mid-run, every register reads back with tag 0 and value 0.
- R2: A source lookup of a register whose tag is 0 returns its value with tag 0. A lookup of a register with a nonzero tag returns that tag with value 0, unless R7 applies.
- R3: When `iss_valid` is 1, the tag of register `iss_dst` becomes `iss_tag` at the next edge. This holds even if an older producer tag was still recorded.
- R4: A broadcast (`bc_valid` = 1) whose nonzero tag equals a register's recorded tag writes `bc_data` into that register and sets its tag to 0.
- R5: A broadcast whose tag differs from a register's recorded tag leaves that register unchanged. This includes an older producer that was overtaken by a later issue.
- R6: If an issue targets a register in the same cycle that a broadcast matches its old tag, the new issue tag is kept after the edge.
- R7: A source lookup of a register whose nonzero tag equals the tag on a valid broadcast in that cycle returns `bc_data` with tag 0.
- R8: Source lookups in an issue cycle see the table as it was before that issue. A source equal to the destination returns the old state.
- R9: With `iss_valid` = 0, the issue fields have no effect. A broadcast with tag 0 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| iss_valid | input | 1 | Issue strobe; records a new producer for `iss_dst` |
| iss_dst | input | 4 | Destination register index |
| iss_tag | input | 4 | Tag of the issuing station |
| src_a_idx | input | 4 | First source register index |
| src_b_idx | input | 4 | Second source register index |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | 4 | Tag of the station that produced the broadcast |
| bc_data | input | 64 | Broadcast result value |
| src_a_tag | output | 4 | Producer tag for the first source, 0 when a value is delivered |
| src_a_val | output | 64 | Value of the first source when its tag output is 0 |
| src_b_tag | output | 4 | Producer tag for the second source, 0 when a value is delivered |
| src_b_val | output | 64 | Value of the second source when its tag output is 0 |

## Verification
A wrong tag in a slot shows up on a source lookup of that register in the cycle after the faulty write. It shows either as the wrong producer or as a value returned too early. A wrongly applied or missed broadcast appears later, on the first lookup after the real producer completes: the register returns stale or overwritten data. The stimulus therefore reads back each register touched, in the cycle right after every issue and broadcast. It also drives overtaken producers, same-cycle issue and completion, and same-cycle bypass, so that the effect of each is pinned to a single edge.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int unsigned FRT_NUM_REGS  = 16;
  localparam int unsigned FRT_TAG_BITS  = 4;
  localparam int unsigned FRT_DATA_BITS = 64;
endpackage

// File: rtl/frt_reset_sync.sv
module frt_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/frt_slot.sv
module frt_slot #(
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic [TAG_W-1:0]  tag_q,
  output logic [DATA_W-1:0] val_q
);
  localparam logic [TAG_W-1:0] NO_TAG = '0;

  logic              bc_hit;
  logic              tag_en;
  logic [TAG_W-1:0]  tag_d;
  logic [DATA_W-1:0] val_d;

  // next state: a new issue wins over clearing; value follows any tag match
  always_comb begin
    bc_hit = bc_valid && (bc_tag != NO_TAG) && (bc_tag == tag_q);
    tag_en = wr_en || bc_hit;
    tag_d  = wr_en ? wr_tag : NO_TAG;
    val_d  = bc_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= NO_TAG;
      val_q <= '0;
    end else begin
      if (tag_en) tag_q <= tag_d;
      if (bc_hit) val_q <= val_d;
    end
  end

  // R3: an issue always leaves its own tag behind
  a_r3_issue_records: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tag_q == $past(wr_tag)));

  // R4: matching completion without issue frees the slot and stores data
  a_r4_match_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_tag != NO_TAG && bc_tag == tag_q && !wr_en)
    |=> (tag_q == NO_TAG && val_q == $past(bc_data)));

  // R5: a foreign or stale tag touches nothing
  a_r5_stale_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_tag != tag_q && !wr_en) |=> ($stable(val_q) && $stable(tag_q)));

  // R6: collision keeps the younger tag, value still captured
  a_r6_collision: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bc_valid && bc_tag != NO_TAG && bc_tag == tag_q)
    |=> (tag_q == $past(wr_tag) && val_q == $past(bc_data)));
endmodule

// File: rtl/frt_lookup.sv
module frt_lookup #(
  parameter int unsigned NREG   = 16,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [TAG_W-1:0]  tags   [NREG],
  input  logic [DATA_W-1:0] vals   [NREG],
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_val
);
  localparam logic [TAG_W-1:0] NO_TAG = '0;

  logic [TAG_W-1:0]  sel_tag;
  logic [DATA_W-1:0] sel_val;

  always_comb begin
    sel_tag = tags[idx];
    sel_val = vals[idx];
    if (sel_tag == NO_TAG) begin
      out_tag = NO_TAG;
      out_val = sel_val;
    end else if (bc_valid && bc_tag == sel_tag) begin
      out_tag = NO_TAG;
      out_val = bc_data;
    end else begin
      out_tag = sel_tag;
      out_val = '0;
    end
  end

  // R7: a tag about to be resolved on the bus is never handed out
  a_r7_no_live_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && out_tag != NO_TAG) |-> (out_tag != bc_tag));

  // R2: a pending operand carries no value
  a_r2_tag_xor_val: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tag != NO_TAG) |-> (out_val == '0));
endmodule

// File: rtl/fp_rename_table.sv
module fp_rename_table
  import frt_pkg::*;
#(
  parameter int unsigned NREG   = FRT_NUM_REGS,
  parameter int unsigned TAG_W  = FRT_TAG_BITS,
  parameter int unsigned DATA_W = FRT_DATA_BITS,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic [IDX_W-1:0]  src_a_idx,
  input  logic [IDX_W-1:0]  src_b_idx,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic [TAG_W-1:0]  src_a_tag,
  output logic [DATA_W-1:0] src_a_val,
  output logic [TAG_W-1:0]  src_b_tag,
  output logic [DATA_W-1:0] src_b_val
);
  logic              rst_ns;
  logic [NREG-1:0]   wr_sel;
  logic [TAG_W-1:0]  slot_tag [NREG];
  logic [DATA_W-1:0] slot_val [NREG];

  frt_reset_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  always_comb begin
    wr_sel = '0;
    if (iss_valid) wr_sel[iss_dst] = 1'b1;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    frt_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_ns),
      .wr_en    (wr_sel[g]),
      .wr_tag   (iss_tag),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .tag_q    (slot_tag[g]),
      .val_q    (slot_val[g])
    );
  end

  frt_lookup #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_look_a (
    .clk      (clk),
    .rst_n    (rst_ns),
    .idx      (src_a_idx),
    .tags     (slot_tag),
    .vals     (slot_val),
    .bc_valid (bc_valid),
    .bc_tag   (bc_tag),
    .bc_data  (bc_data),
    .out_tag  (src_a_tag),
    .out_val  (src_a_val)
  );

  frt_lookup #(.NREG(NREG), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_look_b (
    .clk      (clk),
    .rst_n    (rst_ns),
    .idx      (src_b_idx),
    .tags     (slot_tag),
    .vals     (slot_val),
    .bc_valid (bc_valid),
    .bc_tag   (bc_tag),
    .bc_data  (bc_data),
    .out_tag  (src_b_tag),
    .out_val  (src_b_val)
  );

  // R9: without an issue strobe no slot is selected for writing
  a_r9_no_stray_write: assert property (@(posedge clk) disable iff (!rst_ns)
    !iss_valid |-> (wr_sel == '0));

  // R3: exactly one slot takes the issue tag
  a_r3_one_dest: assert property (@(posedge clk) disable iff (!rst_ns)
    iss_valid |-> $onehot0(wr_sel) && (wr_sel != '0));
endmodule

// File: tb/test_fp_rename_table.sv
module test_fp_rename_table;
  logic        clk;
  logic        rst_n;
  logic        iss_valid;
  logic [3:0]  iss_dst;
  logic [3:0]  iss_tag;
  logic [3:0]  src_a_idx;
  logic [3:0]  src_b_idx;
  logic        bc_valid;
  logic [3:0]  bc_tag;
  logic [63:0] bc_data;
  logic [3:0]  src_a_tag;
  logic [63:0] src_a_val;
  logic [3:0]  src_b_tag;
  logic [63:0] src_b_val;

  int n_checks = 0;
  int n_errors = 0;

  fp_rename_table i_fp_rename_table (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .src_a_idx(src_a_idx), .src_b_idx(src_b_idx),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .src_a_tag(src_a_tag), .src_a_val(src_a_val),
    .src_b_tag(src_b_tag), .src_b_val(src_b_val)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        iv;
    logic [3:0]  dst;
    logic [3:0]  itag;
    logic [3:0]  sa;
    logic        cv;
    logic [3:0]  ctag;
    logic [15:0] cdata;
    logic [3:0]  etag;
    logic [15:0] eval;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd0, 4'd0, 4'd3, 1'b0, 4'd0, 16'h0000, 4'd0, 16'h0000, 4'd1}, // R1 reset view
    '{1'b1, 4'd3, 4'd5, 4'd3, 1'b0, 4'd0, 16'h0000, 4'd0, 16'h0000, 4'd8}, // R8 read before issue
    '{1'b0, 4'd0, 4'd0, 4'd3, 1'b1, 4'd7, 16'h0011, 4'd5, 16'h0000, 4'd5}, // R5 foreign tag
    '{1'b1, 4'd3, 4'd9, 4'd3, 1'b0, 4'd0, 16'h0000, 4'd5, 16'h0000, 4'd2}, // R2 pending tag
    '{1'b0, 4'd0, 4'd0, 4'd3, 1'b1, 4'd5, 16'hAAAA, 4'd9, 16'h0000, 4'd3}, // R3 overwritten
    '{1'b0, 4'd0, 4'd0, 4'd3, 1'b0, 4'd0, 16'h0000, 4'd9, 16'h0000, 4'd5}, // R5 stale dropped
    '{1'b0, 4'd0, 4'd0, 4'd3, 1'b1, 4'd9, 16'h1234, 4'd0, 16'h1234, 4'd7}, // R7 bypass
    '{1'b0, 4'd0, 4'd0, 4'd3, 1'b0, 4'd0, 16'h0000, 4'd0, 16'h1234, 4'd4}, // R4 written
    '{1'b1, 4'd4, 4'd2, 4'd4, 1'b0, 4'd0, 16'h0000, 4'd0, 16'h0000, 4'd2}, // R2 value path
    '{1'b1, 4'd4, 4'd6, 4'd4, 1'b1, 4'd2, 16'h0BEE, 4'd0, 16'h0BEE, 4'd7}, // R7 bypass in issue
    '{1'b0, 4'd0, 4'd0, 4'd4, 1'b0, 4'd0, 16'h0000, 4'd6, 16'h0000, 4'd6}, // R6 young tag kept
    '{1'b0, 4'd0, 4'd0, 4'd4, 1'b1, 4'd6, 16'h0C0D, 4'd0, 16'h0C0D, 4'd7}, // R7
    '{1'b0, 4'd0, 4'd0, 4'd4, 1'b0, 4'd0, 16'h0000, 4'd0, 16'h0C0D, 4'd4}, // R4
    '{1'b0, 4'd4, 4'd3, 4'd4, 1'b0, 4'd0, 16'h0000, 4'd0, 16'h0C0D, 4'd9}, // R9 strobe low
    '{1'b0, 4'd0, 4'd0, 4'd4, 1'b1, 4'd0, 16'hFFFF, 4'd0, 16'h0C0D, 4'd9}, // R9 no change, tag 0 bus
    '{1'b0, 4'd0, 4'd0, 4'd4, 1'b0, 4'd0, 16'h0000, 4'd0, 16'h0C0D, 4'd9}, // R9 tag 0 ignored
    '{1'b0, 4'd0, 4'd0, 4'd3, 1'b0, 4'd0, 16'h0000, 4'd0, 16'h1234, 4'd4}, // R4 other reg intact
    '{1'b0, 4'd0, 4'd0, 4'd0, 1'b0, 4'd0, 16'h0000, 4'd0, 16'h0000, 4'd1}  // R1 untouched reg
  };

  task automatic check(input string req, input logic [3:0] gt, input logic [3:0] et,
                       input logic [63:0] gv, input logic [63:0] ev);
    n_checks++;
    if (gt !== et || gv !== ev) begin
      n_errors++;
      $display("FAIL %s: tag=%0d val=%h expected tag=%0d val=%h", req, gt, gv, et, ev);
    end
  endtask

  task automatic idle();
    iss_valid = 1'b0; iss_dst = '0; iss_tag = '0;
    bc_valid = 1'b0; bc_tag = '0; bc_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    idle();
    src_a_idx = '0; src_b_idx = '0;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      iss_valid = VEC[i].iv;
      iss_dst   = VEC[i].dst;
      iss_tag   = VEC[i].itag;
      src_a_idx = VEC[i].sa;
      bc_valid  = VEC[i].cv;
      bc_tag    = VEC[i].ctag;
      bc_data   = {48'h0, VEC[i].cdata};
      #1;
      check($sformatf("R%0d vec%0d", VEC[i].req, i), src_a_tag, VEC[i].etag,
            src_a_val, {48'h0, VEC[i].eval});
      @(negedge clk);
    end
    idle();

    // R2 second port: register 3 holds 0x1234, boundary index 15 gets tag 15
    src_b_idx = 4'd3; #1;
    check("R2 port b value", src_b_tag, 4'd0, src_b_val, 64'h1234);
    @(negedge clk);
    iss_valid = 1'b1; iss_dst = 4'd15; iss_tag = 4'd15; src_b_idx = 4'd15;
    @(negedge clk);
    idle(); #1;
    check("R3 index 15 tag 15", src_b_tag, 4'd15, src_b_val, 64'h0);
    @(negedge clk);
    bc_valid = 1'b1; bc_tag = 4'd15; bc_data = 64'hDEAD_BEEF_0123_4567;
    src_a_idx = 4'd15; #1;
    check("R7 port a full width", src_a_tag, 4'd0, src_a_val, 64'hDEAD_BEEF_0123_4567);
    @(negedge clk);
    idle(); #1;
    check("R4 full width stored", src_b_tag, 4'd0, src_b_val, 64'hDEAD_BEEF_0123_4567);

    // R1 mid-run reset wipes values and pending tags
    @(negedge clk);
    iss_valid = 1'b1; iss_dst = 4'd7; iss_tag = 4'd1;
    @(negedge clk);
    idle();
    do_reset();
    src_a_idx = 4'd7; src_b_idx = 4'd15; #1;
    check("R1 pending cleared", src_a_tag, 4'd0, src_a_val, 64'h0);
    check("R1 value cleared", src_b_tag, 4'd0, src_b_val, 64'h0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule